// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block drives the reset of a processor system from two sources: the health of the supply and the activity of the software. A comparator outside the block reports supply health as a single level that is already synchronous to the block clock. While that level is low, reset is held. Once it rises, reset is released only after the level has stayed high for a full power-on delay.

After release, an optional watchdog watches a kick input that the processor toggles. Each falling edge of the synchronized kick restarts the timeout. If the timeout expires, the block issues a reset pulse of fixed width. After the pulse it starts timing again from zero, so a stalled processor sees a train of pulses.

All three durations are counted in clock cycles and come from one parameter, the pulse width `PULSE_CYC`. The timeout is five times that value and the power-on delay is fifty times it. Reset appears on two registered outputs of opposite polarity.

Top module: `rst_supervisor`

## Requirements
- R1: `sys_rst_hi` and `sys_rst_n` are always logical complements. While `rst` is high and at the first sample after it, `sys_rst_hi` is 1.
- R2: If `supply_ok` is 0 at a rising edge, `sys_rst_hi` is 1 after that edge. This aborts any watchdog timeout or reset pulse in progress, and the power-on delay restarts from zero.
- R3: `sys_rst_hi` falls to 0 right after the rising edge at which `supply_ok` has been 1 at POR_CYC = 50·PULSE_CYC consecutive edges. Any edge with `supply_ok` at 0 restarts the count.
- R4: When reset is released and `wd_en` is 1, the timeout is TO_CYC = 5·PULSE_CYC edges. If that many edges pass with no recognized kick edge, `sys_rst_hi` rises right after the TO_CYC-th edge.
- R5: A watchdog reset pulse keeps `sys_rst_hi` at 1 for exactly PULSE_CYC cycles. Reset is then released and the timeout restarts from zero, so the pulses repeat every TO_CYC+PULSE_CYC cycles while no kick arrives.
- R6: `wd_kick` passes through a two-flop synchronizer. Only a 1-to-0 change of the synchronized level restarts the timeout. A rising change has no effect.
- R7: While `wd_en` is 0, the watchdog never asserts reset and its timer is held at zero. When `wd_en` rises, a full TO_CYC timeout is counted from that point.
- R8: Kick edges that occur while reset is asserted are ignored. The timeout starts from zero at the edge that releases reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high initialisation |
| supply_ok | input | 1 | Supply healthy, synchronous to clk |
| wd_en | input | 1 | Watchdog enable, active high |
| wd_kick | input | 1 | Processor kick, may be asynchronous |
| sys_rst_hi | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The assertions assume that `supply_ok` and `wd_en` are already synchronous to `clk`. They also assume that each level of `wd_kick` is held for several cycles, so the two-flop synchronizer sees every falling edge. The bench drives every input on the falling clock edge and keeps each kick level for ten cycles. That gives a kick period well under the timeout. During the power-on delay, the bench stops toggling the kick well before release, so no edge still in the synchronizer can land in the released state.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_POR   = 2'd0,
        ST_RUN   = 2'd1,
        ST_PULSE = 2'd2
    } sup_state_e;

    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_cmd_t;

    function automatic int por_cycles(input int pulse);
        return 50 * pulse;
    endfunction

    function automatic int tmo_cycles(input int pulse);
        return 5 * pulse;
    endfunction

endpackage

// File: rtl/sup_kick_sync.sv
module sup_kick_sync (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    output logic fall_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= kick_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign fall_o = prev_q & ~sync_q;

    // R6: a recognized falling edge lasts a single cycle
    assert_fall_single_R6: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/sup_counter.sv
module sup_counter #(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  sup_pkg::cnt_cmd_t cmd_i,
    input  logic [CW-1:0]     limit_i,
    output logic              at_end_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cmd_i.clr) begin
            cnt_q <= '0;
        end else if (cmd_i.inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_end_o = (cnt_q == limit_i);

    // R5: the count never runs past the terminal value of the current phase
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.inc && !cmd_i.clr) |-> (cnt_q < limit_i));

endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl #(
    parameter int CW        = 8,
    parameter int PULSE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok_i,
    input  logic              wd_en_i,
    input  logic              kick_fall_i,
    input  logic              at_end_i,
    output sup_pkg::cnt_cmd_t cmd_o,
    output logic [CW-1:0]     limit_o,
    output logic              rst_hi_o,
    output logic              rst_n_o
);
    import sup_pkg::*;

    localparam int POR_CYC = por_cycles(PULSE_CYC);
    localparam int TO_CYC  = tmo_cycles(PULSE_CYC);

    sup_state_e state_q, state_d;
    logic       hi_q, lo_q;

    always_comb begin
        state_d   = state_q;
        cmd_o.clr = 1'b0;
        cmd_o.inc = 1'b0;
        case (state_q)
            ST_RUN:   limit_o = CW'(TO_CYC - 1);
            ST_PULSE: limit_o = CW'(PULSE_CYC - 1);
            default:  limit_o = CW'(POR_CYC - 1);
        endcase
        if (!supply_ok_i) begin
            state_d   = ST_POR;
            cmd_o.clr = 1'b1;
        end else begin
            case (state_q)
                ST_POR: begin
                    if (at_end_i) begin
                        state_d   = ST_RUN;
                        cmd_o.clr = 1'b1;
                    end else begin
                        cmd_o.inc = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!wd_en_i || kick_fall_i) begin
                        cmd_o.clr = 1'b1;
                    end else if (at_end_i) begin
                        state_d   = ST_PULSE;
                        cmd_o.clr = 1'b1;
                    end else begin
                        cmd_o.inc = 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (at_end_i) begin
                        state_d   = ST_RUN;
                        cmd_o.clr = 1'b1;
                    end else begin
                        cmd_o.inc = 1'b1;
                    end
                end
                default: begin
                    state_d   = ST_POR;
                    cmd_o.clr = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_POR;
            hi_q    <= 1'b1;
            lo_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            hi_q    <= (state_d != ST_RUN);
            lo_q    <= (state_d == ST_RUN);
        end
    end

    assign rst_hi_o = hi_q;
    assign rst_n_o  = lo_q;

    // R1: the two separately registered outputs stay complementary
    assert_complement_R1: assert property (@(posedge clk) disable iff (rst)
        rst_hi_o != rst_n_o);

    // R2: a bad supply sample forces reset on the next cycle
    assert_supply_forces_R2: assert property (@(posedge clk) disable iff (rst)
        !supply_ok_i |=> rst_hi_o);

    // R3: release only follows a cycle with a good supply
    assert_release_good_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_hi_o) |-> $past(supply_ok_i));

    // R7: with the watchdog off and the supply good, a released reset stays released
    assert_wd_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!wd_en_i && supply_ok_i && !rst_hi_o) |=> !rst_hi_o);

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int PULSE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic wd_en,
    input  logic wd_kick,
    output logic sys_rst_hi,
    output logic sys_rst_n
);
    localparam int POR_CYC = sup_pkg::por_cycles(PULSE_CYC);
    localparam int CW      = $clog2(POR_CYC + 1);

    logic              kick_fall;
    logic              at_end;
    sup_pkg::cnt_cmd_t cmd;
    logic [CW-1:0]     limit;

    sup_kick_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .kick_i (wd_kick),
        .fall_o (kick_fall)
    );

    sup_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .limit_i  (limit),
        .at_end_o (at_end)
    );

    sup_ctrl #(.CW(CW), .PULSE_CYC(PULSE_CYC)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .supply_ok_i (supply_ok),
        .wd_en_i     (wd_en),
        .kick_fall_i (kick_fall),
        .at_end_i    (at_end),
        .cmd_o       (cmd),
        .limit_o     (limit),
        .rst_hi_o    (sys_rst_hi),
        .rst_n_o     (sys_rst_n)
    );

endmodule

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
    localparam int PULSE = 8;
    localparam int POR   = 50 * PULSE;
    localparam int TO    = 5 * PULSE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0;
    logic wd_en = 1'b1;
    logic wd_kick = 1'b1;
    logic sys_rst_hi, sys_rst_n;
    int   n_checks = 0;
    int   n_err = 0;

    always #10 clk = ~clk;

    rst_supervisor #(.PULSE_CYC(PULSE)) dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .wd_en(wd_en),
        .wd_kick(wd_kick), .sys_rst_hi(sys_rst_hi), .sys_rst_n(sys_rst_n)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        supply_ok = 1'b0;
        wait_n(3);
        chk(sys_rst_hi, 1'b1, "R1 hi in reset");
        chk(sys_rst_n, 1'b0, "R1 lo in reset");
        rst = 1'b0;
        wait_n(1);
        chk(sys_rst_hi, 1'b1, "R1 hi after reset");
    endtask

    task automatic power_up();
        do_reset();
        supply_ok = 1'b1;
        wait_n(POR);
        chk(sys_rst_hi, 1'b0, "R3 released");
    endtask

    task automatic t_por();
        wd_kick = 1'b1;
        do_reset();
        supply_ok = 1'b1;
        wait_n(POR - 1);
        chk(sys_rst_hi, 1'b1, "R3 held one edge early");
        wait_n(1);
        chk(sys_rst_hi, 1'b0, "R3 release time");
        chk(sys_rst_n, 1'b1, "R1 lo released");
    endtask

    task automatic t_por_glitch();
        do_reset();
        supply_ok = 1'b1;
        wait_n(POR / 2);
        supply_ok = 1'b0;
        wait_n(1);
        chk(sys_rst_hi, 1'b1, "R2 glitch holds reset");
        supply_ok = 1'b1;
        wait_n(POR - 1);
        chk(sys_rst_hi, 1'b1, "R3 delay restarted");
        wait_n(1);
        chk(sys_rst_hi, 1'b0, "R3 release after restart");
    endtask

    task automatic t_timeout();
        wd_en = 1'b1;
        wd_kick = 1'b0;
        power_up();
        wd_kick = 1'b1;  // rising change only: must not restart the timer (R6)
        wait_n(TO - 1);
        chk(sys_rst_hi, 1'b0, "R4 R6 before timeout");
        wait_n(1);
        chk(sys_rst_hi, 1'b1, "R4 timeout pulse");
        chk(sys_rst_n, 1'b0, "R1 lo in pulse");
        wait_n(PULSE - 1);
        chk(sys_rst_hi, 1'b1, "R5 pulse end-1");
        wait_n(1);
        chk(sys_rst_hi, 1'b0, "R5 pulse ends");
        wait_n(TO - 1);
        chk(sys_rst_hi, 1'b0, "R5 retime");
        wait_n(1);
        chk(sys_rst_hi, 1'b1, "R5 repeated pulse");
    endtask

    task automatic t_kick();
        int bad = 0;
        wd_en = 1'b1;
        wd_kick = 1'b1;
        power_up();
        for (int i = 0; i < 12; i++) begin
            wd_kick = 1'b0;
            for (int k = 0; k < 10; k++) begin
                wait_n(1);
                if (sys_rst_hi !== 1'b0) bad++;
            end
            wd_kick = 1'b1;
            for (int k = 0; k < 10; k++) begin
                wait_n(1);
                if (sys_rst_hi !== 1'b0) bad++;
            end
        end
        n_checks++;
        if (bad != 0) begin
            n_err++;
            $display("FAIL R6 kicked reset: actual=%0d expected=0", bad);
        end
    endtask

    task automatic t_disabled();
        wd_en = 1'b0;
        wd_kick = 1'b1;
        power_up();
        wait_n(3 * TO);
        chk(sys_rst_hi, 1'b0, "R7 disabled no reset");
        wd_en = 1'b1;
        wait_n(TO - 1);
        chk(sys_rst_hi, 1'b0, "R7 timer was zero");
        wait_n(1);
        chk(sys_rst_hi, 1'b1, "R7 full timeout after enable");
    endtask

    task automatic t_ignored();
        wd_en = 1'b1;
        wd_kick = 1'b1;
        do_reset();
        supply_ok = 1'b1;
        for (int i = 0; i < 10; i++) begin
            wd_kick = 1'b0;
            wait_n(10);
            wd_kick = 1'b1;
            wait_n(10);
        end
        wait_n(POR - 200 - 1);
        chk(sys_rst_hi, 1'b1, "R8 kicks do not shorten delay");
        wait_n(1);
        chk(sys_rst_hi, 1'b0, "R8 release");
        wait_n(TO - 1);
        chk(sys_rst_hi, 1'b0, "R8 timer from release");
        wait_n(1);
        chk(sys_rst_hi, 1'b1, "R8 timeout from release");
    endtask

    task automatic t_abort();
        wd_en = 1'b1;
        wd_kick = 1'b1;
        power_up();
        wait_n(TO / 2);
        supply_ok = 1'b0;
        wait_n(1);
        chk(sys_rst_hi, 1'b1, "R2 abort timeout");
        supply_ok = 1'b1;
        wait_n(POR);
        chk(sys_rst_hi, 1'b0, "R3 re-release");
        wait_n(TO + 2);
        chk(sys_rst_hi, 1'b1, "R4 in pulse");
        supply_ok = 1'b0;
        wait_n(1);
        supply_ok = 1'b1;
        wait_n(PULSE + 2);
        chk(sys_rst_hi, 1'b1, "R2 pulse aborted to full delay");
        wait_n(POR - PULSE - 3);
        chk(sys_rst_hi, 1'b1, "R2 delay edge-1");
        wait_n(1);
        chk(sys_rst_hi, 1'b0, "R2 delay complete");
    endtask

    initial begin
        t_por();
        t_por_glitch();
        t_timeout();
        t_kick();
        t_disabled();
        t_ignored();
        t_abort();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule